// File: doc/BRIEF.md
# Stretchable External Data-Memory Cycle Sequencer

This block times every external data-memory access of a small 8-bit controller bus. A one-clock start pulse hands it an address, a direction and, for writes, a data byte. It then walks a fixed phase sequence: address setup, an active-low read or write strobe, address and data hold, and a one-clock completion pulse. Slow RAMs and peripherals get more time when software raises a 3-bit stretch code, held in a clock-control register outside the block.

The stretch code sets the strobe width. Code 0 gives two clocks and is the fastest setting. Any other code c gives 4·c clocks, so code 1, the usual power-on value, gives four clocks. Every non-zero code also adds one clock of setup and one clock of hold. The block samples the code when an access begins. Reads capture the data bus on the final strobe clock. Only data-memory accesses pass through this sequencer; instruction fetches are timed elsewhere.

Top module: `xmem_cycle_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, rd_n and wr_n are 1, and addr_valid, wdata_oe, capture and done are 0.
- R2: The strobe (rd_n or wr_n) is low for exactly 2 clocks when the stretch code is 0, and for 4·code clocks when the code is 1..7 (4, 8, 12, 16, 20, 24, 28).
- R3: addr_valid rises with the bus address applied 1 clock before the strobe falls for code 0, and 2 clocks before it for codes 1..7.
- R4: addr_valid stays high for 1 clock after the strobe rises for code 0, and for 2 clocks for codes 1..7.
- R5: A read (is_write=0) drives only rd_n low and a write (is_write=1) drives only wr_n low; the two are never low together.
- R6: For a write, wdata_oe is high for the whole strobe and the whole hold phase, and only then; for a read it stays 0.
- R7: For a read, capture is high only on the last strobe clock, and rdata_q then holds the rdata value present in that clock.
- R8: The stretch code is sampled in the cycle in which start is accepted; a change made during an access alters only the next access.
- R9: done is high for exactly one clock, in the first clock after the hold phase. A start seen during an access or during the done clock is ignored. A start in the clock after done is accepted.
- R10: bus_addr and bus_wdata keep the values of addr and wdata from the accepting cycle for as long as addr_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Access request, accepted when idle |
| is_write | input | 1 | 1 = write, 0 = read |
| addr | input | AW (16) | Access address |
| wdata | input | DW (8) | Write data |
| stretch_code | input | 3 | Stretch setting from clock-control register |
| rdata | input | DW (8) | External data bus for reads |
| bus_addr | output | AW (16) | Address held for the access |
| bus_wdata | output | DW (8) | Write data held for the access |
| wdata_oe | output | 1 | Write data drive enable |
| addr_valid | output | 1 | Address-valid window |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| capture | output | 1 | Read data sample point |
| rdata_q | output | DW (8) | Captured read data |
| done | output | 1 | One-clock completion pulse |

## Verification
A table of accesses covers every stretch code, both reads and writes, and several address and data values. For each access the bench measures the setup, strobe and hold clocks separately. This separates an error in the strobe width from an error in the margin clocks, and shows whether a read and a write at the same code time alike. During reads the bench changes rdata on every strobe clock, so the captured byte shows exactly which clock was sampled. Directed cases change the code in the middle of an access, send a start while busy and during done, and then start again at once after done.

// File: rtl/xmc_pkg.sv
package xmc_pkg;
    localparam int CODE_W     = 3;
    localparam int MAX_STROBE = 4 * ((1 << CODE_W) - 1);
    localparam int STRB_CW    = $clog2(MAX_STROBE + 1);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic [STRB_CW-1:0] strobe_len;
        logic               margin;
    } timing_t;

    function automatic timing_t decode_code(input logic [CODE_W-1:0] code);
        timing_t t;
        t.margin     = (code != '0);
        t.strobe_len = (code == '0) ? STRB_CW'(2) : STRB_CW'({code, 2'b00});
        return t;
    endfunction
endpackage

// File: rtl/xmc_stretch_latch.sv
module xmc_stretch_latch
    import xmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CODE_W-1:0] code,
    output timing_t           tim_new,
    output timing_t           tim_q
);
    localparam logic [CODE_W-1:0] RESET_CODE = CODE_W'(1);

    assign tim_new = decode_code(code);

    always_ff @(posedge clk) begin
        if (rst) begin
            tim_q <= decode_code(RESET_CODE);
        end else if (load) begin
            tim_q <= tim_new;
        end
    end
endmodule

// File: rtl/xmc_phase_seq.sv
module xmc_phase_seq
    import xmc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    accept,
    input  timing_t tim_new,
    input  timing_t tim_q,
    output phase_e  phase,
    output logic    last_tick
);
    logic [STRB_CW-1:0] cnt;

    assign last_tick = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        phase <= PH_SETUP;
                        cnt   <= STRB_CW'(tim_new.margin);
                    end
                end
                PH_SETUP: begin
                    if (last_tick) begin
                        phase <= PH_STROBE;
                        cnt   <= tim_q.strobe_len - STRB_CW'(1);
                    end else begin
                        cnt <= cnt - STRB_CW'(1);
                    end
                end
                PH_STROBE: begin
                    if (last_tick) begin
                        phase <= PH_HOLD;
                        cnt   <= STRB_CW'(tim_q.margin);
                    end else begin
                        cnt <= cnt - STRB_CW'(1);
                    end
                end
                PH_HOLD: begin
                    if (last_tick) begin
                        phase <= PH_DONE;
                    end else begin
                        cnt <= cnt - STRB_CW'(1);
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/xmem_cycle_seq.sv
module xmem_cycle_seq
    import xmc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_write,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  logic [CODE_W-1:0] stretch_code,
    input  logic [DW-1:0]     rdata,
    output logic [AW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_wdata,
    output logic              wdata_oe,
    output logic              addr_valid,
    output logic              rd_n,
    output logic              wr_n,
    output logic              capture,
    output logic [DW-1:0]     rdata_q,
    output logic              done
);
    timing_t tim_new;
    timing_t tim_q;
    phase_e  phase;
    logic    last_tick;
    logic    accept;
    logic    write_q;
    logic    in_strobe;

    assign accept = start && (phase == PH_IDLE);

    xmc_stretch_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .code    (stretch_code),
        .tim_new (tim_new),
        .tim_q   (tim_q)
    );

    xmc_phase_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .tim_new   (tim_new),
        .tim_q     (tim_q),
        .phase     (phase),
        .last_tick (last_tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_addr  <= '0;
            bus_wdata <= '0;
            write_q   <= 1'b0;
        end else if (accept) begin
            bus_addr  <= addr;
            bus_wdata <= wdata;
            write_q   <= is_write;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= rdata;
        end
    end

    assign in_strobe  = (phase == PH_STROBE);
    assign addr_valid = (phase == PH_SETUP) || in_strobe || (phase == PH_HOLD);
    assign rd_n       = !(in_strobe && !write_q);
    assign wr_n       = !(in_strobe && write_q);
    assign wdata_oe   = write_q && (in_strobe || (phase == PH_HOLD));
    assign capture    = in_strobe && !write_q && last_tick;
    assign done       = (phase == PH_DONE);
endmodule

// File: rtl/xmem_cycle_chk.sv
module xmem_cycle_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] bus_addr,
    input logic          wdata_oe,
    input logic          addr_valid,
    input logic          rd_n,
    input logic          wr_n,
    input logic          capture,
    input logic          done
);
    // R5
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    // R2
    min_rd_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_n) |=> !rd_n);

    // R2
    min_wr_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_n) |=> !wr_n);

    // R3
    setup_before_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(rd_n) || $fell(wr_n)) |-> $past(addr_valid));

    // R4
    hold_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(rd_n) || $rose(wr_n)) |-> addr_valid);

    // R6
    wr_drives_data_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> wdata_oe);

    // R7
    capture_last_chk: assert property (@(posedge clk) disable iff (rst)
        capture |-> (!rd_n ##1 rd_n));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!addr_valid && rd_n && wr_n && !wdata_oe));

    // R10
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && $past(addr_valid)) |-> $stable(bus_addr));
endmodule

bind xmem_cycle_seq xmem_cycle_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .wdata_oe   (wdata_oe),
    .addr_valid (addr_valid),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .capture    (capture),
    .done       (done)
);

// File: tb/tb_xmem_cycle_seq.sv
module tb_xmem_cycle_seq;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int NV = 12;

    // entry: {code[2:0], is_write, addr[15:0], data[7:0]}
    localparam logic [27:0] VEC [NV] = '{
        {3'd0, 1'b1, 16'h1234, 8'hA5},
        {3'd0, 1'b0, 16'h0001, 8'h10},
        {3'd1, 1'b1, 16'hFFFF, 8'h3C},
        {3'd1, 1'b0, 16'h8000, 8'h20},
        {3'd2, 1'b0, 16'h00F0, 8'h40},
        {3'd3, 1'b1, 16'h5A5A, 8'hC3},
        {3'd4, 1'b0, 16'hA5A5, 8'h7F},
        {3'd5, 1'b1, 16'h0F0F, 8'h01},
        {3'd6, 1'b0, 16'hBEEF, 8'hF0},
        {3'd7, 1'b1, 16'hCAFE, 8'h99},
        {3'd7, 1'b0, 16'h0100, 8'hE8},
        {3'd2, 1'b1, 16'h7777, 8'h55}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          is_write = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [2:0]    stretch_code = 3'd1;
    logic [DW-1:0] rdata = '0;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          wdata_oe, addr_valid, rd_n, wr_n, capture, done;
    logic [DW-1:0] rdata_q;

    int nvec = 0;
    int nerr = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            nerr = nerr + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    xmem_cycle_seq #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst(rst), .start(start), .is_write(is_write), .addr(addr),
        .wdata(wdata), .stretch_code(stretch_code), .rdata(rdata),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .wdata_oe(wdata_oe),
        .addr_valid(addr_valid), .rd_n(rd_n), .wr_n(wr_n), .capture(capture),
        .rdata_q(rdata_q), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nvec = nvec + 1;
        if (!ok) begin
            nerr = nerr + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_width(input logic [2:0] c);
        return (c == 3'd0) ? 2 : 4 * int'(c);
    endfunction

    function automatic int exp_margin(input logic [2:0] c);
        return (c == 3'd0) ? 1 : 2;
    endfunction

    // Runs one access from an idle cycle; returns at the negedge after done.
    // chg_at > 0 changes the stretch code in that cycle; poke_at > 0 pulses start.
    task automatic run_access(input logic [2:0] c, input logic wr,
                              input logic [AW-1:0] a, input logic [DW-1:0] d,
                              input int chg_at, input logic [2:0] chg_code,
                              input int poke_at);
        int n_setup = 0, n_strb = 0, n_hold = 0, n_oe = 0, n_cap = 0, cap_idx = 0;
        int wrong = 0, addr_bad = 0, cyc = 0;
        bit seen_done = 0;
        int w = exp_width(c);
        int m = exp_margin(c);
        stretch_code = c; is_write = wr; addr = a; wdata = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!seen_done && cyc < 100) begin
            cyc = cyc + 1;
            if (chg_at == cyc) stretch_code = chg_code;
            if (poke_at == cyc) begin start = 1'b1; addr = ~a; wdata = ~d; end
            else if (poke_at + 1 == cyc) start = 1'b0;
            if (done) begin
                seen_done = 1;
                check(addr_valid == 1'b0, "R9 done after hold", addr_valid, 0);
            end else if (addr_valid) begin
                if (bus_addr != a) addr_bad = addr_bad + 1;
                if (wr && bus_wdata != d) addr_bad = addr_bad + 1;
                if (!rd_n || !wr_n) begin
                    n_strb = n_strb + 1;
                    if ((wr && !rd_n) || (!wr && !wr_n) || n_hold > 0) wrong = wrong + 1;
                    if (!rd_n) rdata = d + DW'(n_strb - 1);
                end else if (n_strb == 0) n_setup = n_setup + 1;
                else n_hold = n_hold + 1;
                if (wdata_oe) n_oe = n_oe + 1;
                if (capture) begin n_cap = n_cap + 1; cap_idx = n_strb; end
            end else begin
                wrong = wrong + 1;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(seen_done, "R9 done seen", int'(seen_done), 1);
        check(n_strb == w, "R2 strobe width", n_strb, w);
        check(n_setup == m, "R3 setup clocks", n_setup, m);
        check(n_hold == m, "R4 hold clocks", n_hold, m);
        check(wrong == 0, "R5 strobe select", wrong, 0);
        check(n_oe == (wr ? w + m : 0), "R6 write drive", n_oe, wr ? w + m : 0);
        check(addr_bad == 0, "R10 held address/data", addr_bad, 0);
        if (!wr) begin
            check(n_cap == 1 && cap_idx == w, "R7 capture point", cap_idx, w);
            check(rdata_q == d + DW'(w - 1), "R7 captured data",
                  int'(rdata_q), int'(d + DW'(w - 1)));
        end else begin
            check(n_cap == 0, "R7 no capture on write", n_cap, 0);
        end
        check(done == 1'b0, "R9 done one clock", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check(rd_n && wr_n && !addr_valid && !wdata_oe && !capture && !done,
              "R1 in reset", {rd_n, wr_n, addr_valid, wdata_oe, capture, done}, 6'b110000);
        rst = 1'b0;
        @(negedge clk);
        check(rd_n && wr_n && !addr_valid && !done, "R1 after reset",
              {rd_n, wr_n, addr_valid, done}, 4'b1100);

        for (int i = 0; i < NV; i++) begin
            run_access(VEC[i][27:25], VEC[i][24], VEC[i][23:8], VEC[i][7:0], 0, 3'd0, 0);
        end

        // R8: code raised to 7 then dropped to 0 mid-access; code 2 timing expected
        run_access(3'd2, 1'b0, 16'h2468, 8'h11, 2, 3'd7, 0);
        run_access(3'd2, 1'b1, 16'h1357, 8'h22, 3, 3'd0, 0);
        // R8: the new code applies to the following access
        run_access(3'd0, 1'b0, 16'h0042, 8'h33, 0, 3'd0, 0);

        // R9: start while busy is ignored (R10 address unchanged)
        run_access(3'd3, 1'b1, 16'h4321, 8'h66, 0, 3'd0, 4);
        run_access(3'd1, 1'b0, 16'h9999, 8'h77, 0, 3'd0, 2);

        // R9: start in the done clock ignored, accepted the clock after
        stretch_code = 3'd0; is_write = 1'b0; addr = 16'h1111; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && cycles < 140000) @(negedge clk);
        start = 1'b1; addr = 16'h2222; stretch_code = 3'd1;
        @(negedge clk);
        check(addr_valid == 1'b0, "R9 start in done ignored", addr_valid, 0);
        @(negedge clk);
        start = 1'b0;
        check(addr_valid == 1'b1 && bus_addr == 16'h2222, "R9 start after done accepted",
              int'(bus_addr), 16'h2222);
        while (!done && cycles < 140000) @(negedge clk);
        @(negedge clk);

        // R1: reset in the middle of an access returns to idle
        stretch_code = 3'd7; is_write = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(wr_n && !addr_valid && !wdata_oe, "R1 reset mid-access",
              {wr_n, addr_valid, wdata_oe}, 3'b100);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule